// File: doc/BRIEF.md
# Wakeup Pending with Selectable Clear

This block raises a wakeup request, one bit per line, toward an always-on low-power domain and decides how that request is later withdrawn. There are two kinds of lines. Configurable lines are set by a one-cycle edge-detect strobe. Direct lines are set by a level input. Each line has a mode bit. With the mode bit at 0, the request clears by itself. A configurable line drops its request after a fixed number of clock cycles. A direct line drops its request once its level has fallen. With the mode bit at 1, the request stays up until a clear pulse arrives on one of four external sources. A 2-bit select field per line chooses that source.

The mode bits and the select fields sit in three registers behind a simple write port and a combinational read port. One register holds the mode bits. A low register holds the select fields of lines 0 to 15 and a high register holds those of lines 16 to 31. A separate command clears the whole configuration of one line. Only lines whose wakeup target is all domains (parameter `ALL_LINES`) can hold a mode bit or a select field. Every other line always behaves as if its mode bit were 0. Parameter `CFG_LINES` marks which lines are configurable; the remaining lines are direct. No data flows through the block, so all pins are plain control and status pins and none of them uses a valid/ready handshake.

Top module: `wkp_wakeup_ctrl`

## Requirements
- R1: After reset every `wake_req` bit is 0 and all three registers read 0. Register addresses are: 0 = mode bits, 1 = select low, 2 = select high. Address 3 reads 0.
- R2: On a configurable line with an effective mode of 0, a strobe on `edge_stb` sets the request at the next clock edge. The request then stays high for exactly `AUTO_DLY` cycles and drops after that.
- R3: A strobe that arrives while the line's request is already high keeps the request high. It does not restart the automatic delay and does not change the clear selection. A selected clear pulse given in the same cycle as such a strobe still clears the request.
- R4: On a direct line with an effective mode of 0, `wake_req` copies `dir_lvl` one cycle later. The request therefore drops one cycle after the level falls.
- R5: With the mode bit at 1, select code 0, 1, 2 or 3 picks `clr_pulse[0]`, `[1]`, `[2]` or `[3]` respectively. A held request drops at the edge where its selected pulse is sampled high. A pulse on any other source leaves the request high.
- R6: On a direct line with the mode bit at 1, the request stays high after the level falls and drops only on the selected clear pulse.
- R7: The select field of line i sits at bits [2i+1:2i] of the low register for i < 16. For lines 16 to 31 it sits at bits [2(i-16)+1:2(i-16)] of the high register. Mode bit i is bit i of the mode register.
- R8: When `cfg_clr_en` is high at a clock edge, the mode bit and the select field of line `cfg_clr_line` become 0. The configuration of every other line is left as it was.
- R9: On a line whose `ALL_LINES` bit is 0, the mode bit and the select field always read 0, whatever is written to them. Such a line always clears automatically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Address of the register to write |
| wr_data | input | 32 | Data to write |
| rd_addr | input | 2 | Address of the register to read |
| rd_data | output | 32 | Contents of the register at `rd_addr` (combinational) |
| cfg_clr_en | input | 1 | Clear the configuration of one line |
| cfg_clr_line | input | LW | Index of the line whose configuration is cleared |
| edge_stb | input | N_LINES | Edge-detect strobes for the configurable lines |
| dir_lvl | input | N_LINES | Input levels for the direct lines |
| clr_pulse | input | 4 | External clear-source pulses |
| wake_req | output | N_LINES | Wakeup request for each line |

## Verification
The assertions assume that the mode bit and the select field of a line do not change while that line's request is high. The stimulus keeps to this by writing the configuration only while every request is low, and by then waiting for each request to drop. The assertions also take the mode bit and select field held in the registers as the reference for each line. Strobes are driven only on configurable lines and levels only on direct lines. As a result, every rise of a request can be traced back to a trigger in the cycle before it.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
  localparam int FIELD_W   = 2;
  localparam int NUM_SRC   = 4;
  localparam int REG_LINES = 16;

  typedef enum logic [1:0] {
    RA_MODE   = 2'd0,
    RA_SEL_LO = 2'd1,
    RA_SEL_HI = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_DMA_A = 2'd0,
    SRC_DMA_B = 2'd1,
    SRC_TMR_A = 2'd2,
    SRC_TMR_B = 2'd3
  } clr_src_e;

  // Widen a per-line mask to a per-field (2-bit) mask.
  function automatic logic [63:0] widen_mask(input logic [31:0] m);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) r[2*i +: 2] = {2{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/wkp_regs.sv
module wkp_regs
  import wkp_pkg::*;
#(
  parameter int          N_LINES   = 32,
  parameter logic [31:0] ALL_LINES = 32'h00FF_00FF,
  localparam int         LW        = $clog2(N_LINES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [1:0]             rd_addr,
  output logic [31:0]            rd_data,
  input  logic                   cfg_clr_en,
  input  logic [LW-1:0]          cfg_clr_line,
  output logic [N_LINES-1:0]     mode_q,
  output logic [2*N_LINES-1:0]   sel_q
);
  localparam logic [63:0] SEL_KEEP = widen_mask(ALL_LINES);

  logic [31:0] mode_pad, mode_nxt;
  logic [63:0] sel_pad, sel_nxt;

  always_comb begin
    mode_pad = '0;
    mode_pad[N_LINES-1:0] = mode_q;
    sel_pad = '0;
    sel_pad[2*N_LINES-1:0] = sel_q;
  end

  always_comb begin
    mode_nxt = mode_pad;
    sel_nxt  = sel_pad;
    if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        RA_MODE:   mode_nxt        = wr_data;
        RA_SEL_LO: sel_nxt[31:0]   = wr_data;
        RA_SEL_HI: sel_nxt[63:32]  = wr_data;
        default:   ;
      endcase
    end
    if (cfg_clr_en) begin
      mode_nxt[cfg_clr_line] = 1'b0;
      sel_nxt[2*int'(cfg_clr_line) +: FIELD_W] = '0;
    end
    mode_nxt = mode_nxt & ALL_LINES;
    sel_nxt  = sel_nxt & SEL_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_nxt[N_LINES-1:0];
      sel_q  <= sel_nxt[2*N_LINES-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      RA_MODE:   rd_data = mode_pad;
      RA_SEL_LO: rd_data = sel_pad[31:0];
      RA_SEL_HI: rd_data = sel_pad[63:32];
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wkp_line.sv
module wkp_line #(
  parameter bit IS_CFG   = 1'b1,
  parameter int AUTO_DLY = 6,
  localparam int CW      = $clog2(AUTO_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic mode1,
  input  logic clr_hit,
  output logic req
);
  generate
    if (IS_CFG) begin : g_cfg
      logic [CW-1:0] cnt;
      logic          clr;
      assign clr = mode1 ? clr_hit : (cnt == '0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          req <= 1'b0;
          cnt <= '0;
        end else if (req) begin
          req <= !clr;
          if (cnt != '0) cnt <= cnt - 1'b1;
        end else begin
          req <= trig;
          if (trig) cnt <= CW'(AUTO_DLY - 1);
        end
      end
    end else begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               req <= 1'b0;
        else if (req && mode1)    req <= !clr_hit;
        else                      req <= trig;
      end
    end
  endgenerate
endmodule

// File: rtl/wkp_wakeup_ctrl.sv
module wkp_wakeup_ctrl
  import wkp_pkg::*;
#(
  parameter int          N_LINES   = 32,
  parameter int          AUTO_DLY  = 6,
  parameter logic [31:0] CFG_LINES = 32'h0000_FFFF,
  parameter logic [31:0] ALL_LINES = 32'h00FF_00FF,
  localparam int         LW        = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [1:0]         rd_addr,
  output logic [31:0]        rd_data,
  input  logic               cfg_clr_en,
  input  logic [LW-1:0]      cfg_clr_line,
  input  logic [N_LINES-1:0] edge_stb,
  input  logic [N_LINES-1:0] dir_lvl,
  input  logic [NUM_SRC-1:0] clr_pulse,
  output logic [N_LINES-1:0] wake_req
);
  logic [N_LINES-1:0]   mode_q;
  logic [2*N_LINES-1:0] sel_q;

  wkp_regs #(.N_LINES(N_LINES), .ALL_LINES(ALL_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .cfg_clr_en(cfg_clr_en), .cfg_clr_line(cfg_clr_line),
    .mode_q(mode_q), .sel_q(sel_q)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam bit IS_CFG = CFG_LINES[i];
    logic trig, hit;
    assign trig = (edge_stb[i] & IS_CFG) | (dir_lvl[i] & !IS_CFG);
    assign hit  = clr_pulse[sel_q[2*i +: FIELD_W]];
    wkp_line #(.IS_CFG(IS_CFG), .AUTO_DLY(AUTO_DLY)) u_line (
      .clk(clk), .rst_n(rst_n), .trig(trig),
      .mode1(mode_q[i]), .clr_hit(hit), .req(wake_req[i])
    );
  end
endmodule

// File: rtl/wkp_wakeup_ctrl_chk.sv
module wkp_wakeup_ctrl_chk #(
  parameter int          N_LINES   = 32,
  parameter logic [31:0] CFG_LINES = 32'h0000_FFFF,
  parameter logic [31:0] ALL_LINES = 32'h00FF_00FF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_LINES-1:0]   edge_stb,
  input logic [N_LINES-1:0]   dir_lvl,
  input logic [3:0]           clr_pulse,
  input logic [N_LINES-1:0]   wake_req,
  input logic [1:0]           rd_addr,
  input logic [31:0]          rd_data,
  input logic [N_LINES-1:0]   mode_q,
  input logic [2*N_LINES-1:0] sel_q
);
  localparam logic [N_LINES-1:0] CFGM = CFG_LINES[N_LINES-1:0];
  localparam logic [N_LINES-1:0] ALLM = ALL_LINES[N_LINES-1:0];

  logic [N_LINES-1:0] hit, cause;
  logic past_ok;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) hit[i] = clr_pulse[sel_q[2*i +: 2]];
    cause = (edge_stb & CFGM) | (dir_lvl & ~CFGM);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  AST_SET_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((wake_req & ~$past(wake_req) & ~$past(cause)) == '0)); // R2
  AST_DIRECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((wake_req ^ $past(dir_lvl)) & ~CFGM & ~$past(mode_q)) == '0)); // R4
  AST_SEL_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(wake_req & mode_q & hit) & wake_req) == '0)); // R5
  AST_OTHER_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(wake_req & mode_q & ~hit) & ~wake_req) == '0)); // R5
  AST_NARROW_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> ((rd_data[N_LINES-1:0] & ~ALLM) == '0)); // R9
endmodule

bind wkp_wakeup_ctrl wkp_wakeup_ctrl_chk #(
  .N_LINES(N_LINES), .CFG_LINES(CFG_LINES), .ALL_LINES(ALL_LINES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_stb(edge_stb), .dir_lvl(dir_lvl),
  .clr_pulse(clr_pulse), .wake_req(wake_req), .rd_addr(rd_addr),
  .rd_data(rd_data), .mode_q(mode_q), .sel_q(sel_q)
);

// File: tb/wkp_wakeup_ctrl_test.sv
`timescale 1ns/1ps
module wkp_wakeup_ctrl_test;
  localparam int N   = 32;
  localparam int DLY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, cfg_clr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [4:0] cfg_clr_line = '0;
  logic [N-1:0] edge_stb = '0, dir_lvl = '0, wake_req;
  logic [3:0] clr_pulse = '0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wkp_wakeup_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_clr_en(cfg_clr_en),
    .cfg_clr_line(cfg_clr_line), .edge_stb(edge_stb), .dir_lvl(dir_lvl),
    .clr_pulse(clr_pulse), .wake_req(wake_req)
  );

  // {code[4:3], pulse[2:1], stays_held[0]}
  localparam logic [4:0] TBL [8] = '{
    {2'd0, 2'd0, 1'b0}, {2'd0, 2'd1, 1'b1}, {2'd1, 2'd1, 1'b0}, {2'd1, 2'd3, 1'b1},
    {2'd2, 2'd2, 1'b0}, {2'd2, 2'd0, 1'b1}, {2'd3, 2'd3, 1'b0}, {2'd3, 2'd2, 1'b1}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    rd_addr = a; #0.5;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 wake", wake_req, '0);
    rd_chk("R1 mode", 2'd0, '0);
    rd_chk("R1 sel_lo", 2'd1, '0);
    rd_chk("R1 sel_hi", 2'd2, '0);
    rd_chk("R1 spare", 2'd3, '0);

    // R5 source selection table on line 2 (configurable, all-domain)
    wr(2'd0, 32'h0000_0004);
    for (int k = 0; k < 8; k++) begin
      logic [1:0] code, pls;
      code = TBL[k][4:3]; pls = TBL[k][2:1];
      wr(2'd1, 32'(code) << 4);
      edge_stb[2] = 1'b1; tick(); edge_stb[2] = 1'b0;
      chk("R5 set", 32'(wake_req[2]), 32'd1);
      clr_pulse = 4'b1 << pls; tick(); clr_pulse = '0;
      chk("R5 table", 32'(wake_req[2]), 32'(TBL[k][0]));
      if (TBL[k][0]) begin
        clr_pulse = 4'b1 << code; tick(); clr_pulse = '0;
        chk("R5 late clear", 32'(wake_req[2]), 32'd0);
      end
    end
    // R3 mode 1: retrigger together with selected pulse still clears (code 3)
    edge_stb[2] = 1'b1; tick(); edge_stb[2] = 1'b0;
    tick();
    chk("R3 held", 32'(wake_req[2]), 32'd1);
    edge_stb[2] = 1'b1; clr_pulse = 4'b1000; tick();
    edge_stb[2] = 1'b0; clr_pulse = '0;
    chk("R3 retrig+clear", 32'(wake_req[2]), 32'd0);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);

    // R2 automatic clear on line 5
    edge_stb[5] = 1'b1; tick(); edge_stb[5] = 1'b0;
    chk("R2 rise", 32'(wake_req[5]), 32'd1);
    repeat (DLY - 1) tick();
    chk("R2 last high", 32'(wake_req[5]), 32'd1);
    tick();
    chk("R2 dropped", 32'(wake_req[5]), 32'd0);

    // R3 retrigger does not restart the delay
    edge_stb[5] = 1'b1; tick(); edge_stb[5] = 1'b0;
    for (int j = 1; j < DLY; j++) begin
      if (j == 2) edge_stb[5] = 1'b1;
      tick();
      edge_stb[5] = 1'b0;
    end
    chk("R3 still high", 32'(wake_req[5]), 32'd1);
    tick();
    chk("R3 no restart", 32'(wake_req[5]), 32'd0);

    // R9 lines outside the all-domain set
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    rd_chk("R9 mode", 2'd0, 32'h00FF_00FF);
    rd_chk("R9 sel_lo", 2'd1, 32'h0000_FFFF);
    rd_chk("R9 sel_hi", 2'd2, 32'h0000_FFFF);
    edge_stb[0] = 1'b1; edge_stb[10] = 1'b1; tick(); edge_stb = '0;
    repeat (DLY) tick();
    chk("R9 auto vs held", wake_req & 32'h0000_0401, 32'h0000_0001);
    clr_pulse = 4'b1000; tick(); clr_pulse = '0;
    chk("R9 line0 cleared", wake_req, '0);

    // R8 clear one line's configuration
    cfg_clr_en = 1'b1; cfg_clr_line = 5'd3; tick(); cfg_clr_en = 1'b0;
    rd_chk("R8 mode", 2'd0, 32'h00FF_00F7);
    rd_chk("R8 sel_lo", 2'd1, 32'h0000_FF3F);
    rd_chk("R8 sel_hi", 2'd2, 32'h0000_FFFF);

    // R7 field packing: line 1 code 2, line 18 code 3
    wr(2'd1, 32'h0000_0008);
    wr(2'd2, 32'h0000_0030);
    wr(2'd0, 32'h0004_0002);
    rd_chk("R7 mode", 2'd0, 32'h0004_0002);
    rd_chk("R7 sel_lo", 2'd1, 32'h0000_0008);
    rd_chk("R7 sel_hi", 2'd2, 32'h0000_0030);
    edge_stb[1] = 1'b1; tick(); edge_stb[1] = 1'b0;
    clr_pulse = 4'b0001; tick(); clr_pulse = '0;
    chk("R7 line1 other src", 32'(wake_req[1]), 32'd1);
    clr_pulse = 4'b0100; tick(); clr_pulse = '0;
    chk("R7 line1 code2", 32'(wake_req[1]), 32'd0);

    // R6 direct line 18 in mode 1
    dir_lvl[18] = 1'b1; tick(); dir_lvl[18] = 1'b0;
    chk("R6 set", 32'(wake_req[18]), 32'd1);
    tick(); tick();
    chk("R6 held after low", 32'(wake_req[18]), 32'd1);
    clr_pulse = 4'b0100; tick(); clr_pulse = '0;
    chk("R6 wrong src", 32'(wake_req[18]), 32'd1);
    clr_pulse = 4'b1000; tick(); clr_pulse = '0;
    chk("R6 cleared", 32'(wake_req[18]), 32'd0);

    // R4 direct lines 20 (all-domain, mode 0) and 26 (narrow)
    dir_lvl[20] = 1'b1; dir_lvl[26] = 1'b1; tick();
    chk("R4 follow", wake_req & 32'h0410_0000, 32'h0410_0000);
    tick(); tick();
    chk("R4 steady", wake_req & 32'h0410_0000, 32'h0410_0000);
    dir_lvl = '0; tick();
    chk("R4 drop", wake_req, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule